// File: doc/BRIEF.md
# Byte-Lane Steering Unit with 16-bit Port Sizing

This unit takes one 32-bit transfer request at a time from the core side. A request carries a word address, a four-bit byte mask and, for a write, the write data. The unit turns the request into bus cycles on a 32-bit external data bus that has four active-low byte enables. Byte enable *i* qualifies data bits 8*i+7..8*i. Only the word address goes onto the bus. The low address bits are carried only by the enable pattern.

The addressed device reports its width through an active-low 16-bit indication. The unit samples this indication when the first bus cycle completes. If the device is 16 bits wide and the mask covers bytes in both halves, the unit runs a second cycle for the upper half. In that second cycle the upper write data is also copied onto the lower lanes. For reads, the bytes returned over one or two cycles are gathered into a single 32-bit result. Any lane that is not in the mask reads as zero. The unit raises a one-cycle response strobe when the transfer is complete.

Top module: `bus_lane_steer`

## Requirements
- R1: After reset, busy, bus_act and rsp_valid are 0 and bus_be_n is 4'b1111.
- R2: In the first bus cycle of a request, bus_be_n[i] equals the inverse of req_mask[i] (bit i qualifies data bits 8i+7..8i), and bus_addr equals the request word address.
- R3: In a write's first cycle, when req_mask[1:0] is 00, bus_wdata is {wdata[31:16], wdata[31:16]}. Otherwise bus_wdata equals the write data unchanged.
- R4: If bus_half_n is 0 when the first cycle completes, and the mask has bits in both halves, a second cycle follows. In that cycle bus_be_n is {~mask[3:2], 2'b11} and, for a write, bus_wdata is {wdata[31:16], wdata[31:16]}.
- R5: No second cycle is issued when bus_half_n is 1 at first-cycle completion, or when the mask lies within one half. busy is 0 in the cycle after that completion.
- R6: A read answered by a 32-bit device (bus_half_n = 1) returns bus_rdata with every unmasked byte lane forced to zero.
- R7: For a read split over two cycles, result bytes 1..0 are the masked D15..D0 of the first cycle, and result bytes 3..2 are the masked D15..D0 of the second cycle.
- R8: For a read with mask[1:0] = 00 on a 16-bit device, D15..D0 of the single cycle forms result bytes 3..2. A read with mask[3:2] = 00 uses D15..D0 as bytes 1..0. Unmasked lanes are zero, and writes return a zero result.
- R9: busy rises in the cycle after a request is accepted while idle, and stays high until the final cycle completes. A request offered while busy is ignored. rsp_valid pulses for one cycle, in the cycle after the final bus_done.
- R10: While a request is in progress, bus_addr and bus_write stay constant across wait states and across both cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered; taken when busy is 0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_mask | input | 4 | Active-high byte mask |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | A request is in progress |
| bus_act | output | 1 | A bus cycle is being presented |
| bus_addr | output | ADDR_W | Word address on the bus |
| bus_write | output | 1 | Bus cycle direction |
| bus_be_n | output | 4 | Active-low byte enables |
| bus_wdata | output | 32 | Steered write data |
| bus_rdata | input | 32 | Read data from the device |
| bus_done | input | 1 | Current bus cycle completes this clock |
| bus_half_n | input | 1 | Active-low 16-bit device indication, sampled with bus_done |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 32 | Gathered read result |

## Verification
A wrong cycle-sequencing state shows up one clock after the first bus_done: a missing or extra second cycle changes busy and bus_be_n at the next sample. A wrong lane-gathering register, by contrast, stays hidden until rsp_valid, which is the moment it is compared against the bytes the device supplied. The cases that matter are those where the enable pattern, the copied data and the placement of read bytes depend jointly on the mask halves and on the sampled width. So those combinations are driven on both 16-bit and 32-bit devices, with wait states between cycles.

// File: rtl/bus_lane_steer.sv
module bus_lane_steer #(
  parameter int ADDR_W = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_mask,
  input  logic [31:0]       req_wdata,
  output logic              busy,
  output logic              bus_act,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic [3:0]        bus_be_n,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_done,
  input  logic              bus_half_n,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_SECOND} st_t;

  st_t         st;
  logic [3:0]  r_mask;
  logic [31:0] r_wdata;
  logic [31:0] acc;

  logic [31:0] lane_mask;
  logic        hi_any, lo_any, narrow, need_second, final_done;
  logic [31:0] dup;

  assign lane_mask = {{8{r_mask[3]}}, {8{r_mask[2]}}, {8{r_mask[1]}}, {8{r_mask[0]}}};
  assign hi_any    = |r_mask[3:2];
  assign lo_any    = |r_mask[1:0];
  assign narrow    = ~bus_half_n;
  assign need_second = narrow & hi_any & lo_any;
  assign final_done  = bus_done & ((st == S_SECOND) | ((st == S_FIRST) & ~need_second));
  assign dup       = {r_wdata[31:16], r_wdata[31:16]};

  assign busy      = (st != S_IDLE);
  assign bus_act   = busy;
  assign rsp_rdata = acc;

  always_comb begin
    case (st)
      S_FIRST:  bus_be_n = ~r_mask;
      S_SECOND: bus_be_n = {~r_mask[3:2], 2'b11};
      default:  bus_be_n = 4'b1111;
    endcase
  end

  assign bus_wdata = !bus_write ? 32'h0 :
                     ((st == S_SECOND) || !lo_any) ? dup : r_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bus_addr  <= '0;
      bus_write <= 1'b0;
      r_mask    <= 4'h0;
      r_wdata   <= 32'h0;
      acc       <= 32'h0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= final_done;
      case (st)
        S_IDLE: if (req_valid) begin
          st        <= S_FIRST;
          bus_addr  <= req_addr;
          bus_write <= req_write;
          r_mask    <= req_mask;
          r_wdata   <= req_wdata;
          acc       <= 32'h0;
        end
        S_FIRST: if (bus_done) begin
          if (!bus_write) begin
            if (!narrow)      acc <= bus_rdata & lane_mask;
            else if (!lo_any) acc <= {bus_rdata[15:0], 16'h0} & lane_mask;
            else              acc <= {16'h0, bus_rdata[15:0]} & lane_mask;
          end
          st <= need_second ? S_SECOND : S_IDLE;
        end
        S_SECOND: if (bus_done) begin
          if (!bus_write) acc[31:16] <= bus_rdata[15:0] & lane_mask[31:16];
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bus_lane_steer_chk.sv
module bus_lane_steer_chk #(
  parameter int ADDR_W = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              bus_act,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_write,
  input logic [3:0]        bus_be_n,
  input logic [31:0]       bus_wdata,
  input logic              bus_done,
  input logic              rsp_valid
);

  // R1
  idle_be_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> bus_be_n == 4'b1111);

  // R3
  upper_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_act && bus_write && bus_be_n[1:0] == 2'b11) |-> bus_wdata[15:0] == bus_wdata[31:16]);

  // R4
  second_cycle_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_act && $past(bus_act && bus_done)) |-> bus_be_n[1:0] == 2'b11);

  // R9
  accept_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  // R9
  rsp_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(busy && bus_done));

  // R9
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_act && $past(bus_act)) |-> ($stable(bus_addr) && $stable(bus_write)));

endmodule

bind bus_lane_steer bus_lane_steer_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/bus_lane_steer_test.sv
`timescale 1ns/1ps
module bus_lane_steer_test;
  localparam int AW = 30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0]    req_mask = 4'h0;
  logic [31:0]   req_wdata = 32'h0;
  logic          busy, bus_act, bus_write, rsp_valid;
  logic [AW-1:0] bus_addr;
  logic [3:0]    bus_be_n;
  logic [31:0]   bus_wdata, rsp_rdata;
  logic [31:0]   bus_rdata = 32'h0;
  logic          bus_done = 1'b0;
  logic          bus_half_n = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];

  always #2.5 clk = ~clk;

  bus_lane_steer #(.ADDR_W(AW)) uut (.*);

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] expand(input logic [3:0] m);
    return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
  endfunction

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R9 unexpected rsp", rsp_rdata, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R6/R7/R8 result", rsp_rdata, e);
      end
    end
  end

  task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic [3:0] m,
                      input logic [31:0] wd, input logic half, input logic [31:0] rd1,
                      input logic [31:0] rd2, input int waits);
    logic split;
    logic [31:0] dupd, exp_rd, em;
    split = half && (|m[1:0]) && (|m[3:2]);
    dupd  = {wd[31:16], wd[31:16]};
    em    = expand(m);
    if (wr) exp_rd = 32'h0;
    else if (!half) exp_rd = rd1 & em;
    else if (m[1:0] == 2'b00) exp_rd = {rd1[15:0], 16'h0} & em;
    else if (split) exp_rd = {rd2[15:0], rd1[15:0]} & em;
    else exp_rd = {16'h0, rd1[15:0]} & em;
    exp_q.push_back(exp_rd);

    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_mask = m; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R9 busy after accept", {31'h0, busy}, 32'h1);
    chk(bus_be_n == ~m, "R2 first enables", {28'h0, bus_be_n}, {28'h0, ~m});
    chk(bus_addr == a, "R2 address", {2'b0, bus_addr}, {2'b0, a});
    if (wr) begin
      if (m[1:0] == 2'b00) chk(bus_wdata == dupd, "R3 upper copy", bus_wdata, dupd);
      else chk(bus_wdata == wd, "R3 unchanged data", bus_wdata, wd);
    end
    for (int i = 0; i < waits; i++) begin
      req_valid = 1'b1; req_addr = ~a; req_write = ~wr;
      @(negedge clk);
      req_valid = 1'b0;
      chk(bus_addr == a && bus_write == wr, "R9 ignored request / R10 hold", {2'b0, bus_addr}, {2'b0, a});
    end
    bus_done = 1'b1; bus_half_n = ~half; bus_rdata = rd1;
    @(negedge clk);
    bus_done = 1'b0; bus_half_n = 1'b1; bus_rdata = 32'hDEAD_BEEF;
    if (split) begin
      chk(busy == 1'b1, "R4 second cycle present", {31'h0, busy}, 32'h1);
      chk(bus_be_n == {~m[3:2], 2'b11}, "R4 second enables", {28'h0, bus_be_n}, {28'h0, ~m[3:2], 2'b11});
      chk(bus_addr == a, "R10 address in second cycle", {2'b0, bus_addr}, {2'b0, a});
      if (wr) chk(bus_wdata == dupd, "R4 second data copy", bus_wdata, dupd);
      bus_done = 1'b1; bus_half_n = 1'b0; bus_rdata = rd2;
      @(negedge clk);
      bus_done = 1'b0; bus_half_n = 1'b1; bus_rdata = 32'hDEAD_BEEF;
    end else begin
      chk(busy == 1'b0, "R5 no second cycle", {31'h0, busy}, 32'h0);
    end
    chk(rsp_valid == 1'b1, "R9 rsp strobe", {31'h0, rsp_valid}, 32'h1);
    chk(busy == 1'b0, "R9 busy released", {31'h0, busy}, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during and after reset
    chk(busy == 1'b0 && rsp_valid == 1'b0, "R1 reset status", {30'h0, busy, rsp_valid}, 32'h0);
    chk(bus_be_n == 4'hF && bus_act == 1'b0, "R1 reset enables", {27'h0, bus_act, bus_be_n}, 32'hF);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_be_n == 4'hF && busy == 1'b0, "R1 idle after reset", {27'h0, busy, bus_be_n}, 32'hF);

    xfer(1, 30'h0000123, 4'b1111, 32'h7C06_83C2, 1, 0, 0, 0);   // R4 full write, 16-bit
    xfer(1, 30'h0000124, 4'b1111, 32'h1122_3344, 0, 0, 0, 1);   // R5 32-bit device
    xfer(1, 30'h0000200, 4'b1000, 32'hAB00_0000, 0, 0, 0, 0);   // R3 upper byte copy
    xfer(1, 30'h0000201, 4'b0011, 32'h0000_AA55, 1, 0, 0, 0);   // R5 lower half, 16-bit
    xfer(1, 30'h0000202, 4'b0110, 32'h00EB_0A00, 1, 0, 0, 2);   // R4 mixed, waits
    xfer(1, 30'h0000203, 4'b1100, 32'hEB0A_0000, 1, 0, 0, 0);   // R3/R5 upper half 16-bit
    xfer(0, 30'h0000300, 4'b1111, 0, 0, 32'h0AEB_AA55, 0, 0);   // R6
    xfer(0, 30'h0000301, 4'b0110, 0, 0, 32'h1234_5678, 0, 1);   // R6 masked lanes
    xfer(0, 30'h0000302, 4'b1111, 0, 1, 32'hFFFF_83C2, 32'h5555_7C06, 1); // R7
    xfer(0, 30'h0000303, 4'b0101, 0, 1, 32'h9999_1234, 32'h8888_5678, 0); // R7 sparse
    xfer(0, 30'h0000304, 4'b1100, 0, 1, 32'h7777_BEEF, 0, 0);   // R8 upper on 16-bit
    xfer(0, 30'h0000305, 4'b0001, 0, 1, 32'hCCCC_DD42, 0, 2);   // R8 lower byte
    xfer(0, 30'h0000306, 4'b1111, 0, 0, 32'hCAFE_F00D, 0, 0);   // R5 full read 32-bit

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all responses seen", exp_q.size(), 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule